// File: doc/BRIEF.md
# Oversampled SPI Slave Engine

This block is an SPI slave that lives entirely in the system clock domain. It never uses the serial clock as a clock. The serial clock, select and data-in lines each pass through a two-stage synchroniser. The block then finds serial clock edges by comparing successive synchronised samples. Received bits are gathered MSB first into a byte, which is presented with a one-cycle strobe. Outgoing bytes come from a data input that carries a valid qualifier, such as the read port of a RAM. The block signals each byte it takes with a one-cycle take pulse.

Clock polarity, clock phase and the stall limit are copied from the configuration inputs only while no frame is in progress, so a change made during a frame takes effect at the next one. The block also handles three fault cases:
- If select is released part-way through a byte, it reports an abort and discards the partial byte.
- If the serial clock stops for too long, it flags a timeout and stays silent for the rest of the frame.
- If transmit data is not ready when a byte must be loaded, it sends a fill byte and flags an underrun.

The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi_os_slave`

## Requirements
- R1: Data-in is sampled on each sample edge and shifted in MSB first. After every eighth sampled bit, `rx_data` holds the byte and `rx_valid` is high for exactly one cycle.
- R2: `miso` carries the transmit byte MSB first and advances one bit on each drive edge. When phase is 0, bit 7 of the first byte is on `miso` as soon as the select assertion has been synchronised, before any serial clock edge.
- R3: All four modes work. The leading edge is the edge that leaves the idle level `cfg_cpol` (idle 0 gives a rising leading edge). When phase is 0, sampling happens on the leading edge and driving on the trailing edge. When phase is 1, this is reversed.
- R4: Releasing select after 1 to 7 bits of a byte raises `rx_abort` for one cycle and gives no `rx_valid` for the partial byte. The next frame starts again at bit 7.
- R5: A transmit byte is fetched at frame start and on the first drive edge after each completed byte. `tx_take` pulses for one cycle only when `tx_valid` is high. If `tx_valid` is low at a fetch, the fill byte 8'hFF is sent and `tx_underrun` goes high and stays high until the next frame start.
- R6: If no serial clock edge arrives for `cfg_stall` system cycles while selected, `stall_timeout` goes high. For the rest of that frame, `miso` idles, clock edges are ignored, no byte completes and no abort is reported. `stall_timeout` stays high until the next frame start clears it.
- R7: `cfg_cpol`, `cfg_cpha` and `cfg_stall` are captured only while the slave is not in a frame. Changing them mid-frame does not alter how that frame is clocked, and the new values apply from the next frame.
- R8: While deselected, `miso` is held at 1 and activity on `sclk` and `mosi` produces no `rx_valid`.
- R9: While `rst_n` is low, `miso` is 1 and `rx_valid`, `tx_take`, `rx_abort`, `tx_underrun` and `stall_timeout` are 0, whatever the serial inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level for the next frame |
| cfg_cpha | input | 1 | Clock phase for the next frame |
| cfg_stall | input | STALL_W | Stall limit in system cycles for the next frame |
| sclk | input | 1 | Serial clock from the master, sampled as data |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_data` may be taken |
| tx_take | output | 1 | One-cycle pulse when `tx_data` is consumed |
| tx_underrun | output | 1 | A fill byte was sent in this frame |
| rx_abort | output | 1 | One-cycle pulse when a frame ended mid-byte |
| stall_timeout | output | 1 | The serial clock stalled in this frame |

## Verification
The bench aims at the places where edge roles and byte boundaries meet:
- **Phase 1 first byte.** A slave that shifts on the first leading edge of a phase-1 frame loses bit 7 of the first byte.
- **Byte boundary fetch.** A slave that fetches on the wrong edge sends stale data after a byte boundary.
- **Mid-frame configuration change.** Writing new configuration mid-frame would turn the remaining edges into the wrong roles and scramble the second byte if configuration were not latched.
- **Release mid-byte.** A slave that does not discard partial bits would report a bogus byte, or would carry stray bits into the next frame.
- **Stall.** After a stall the bench keeps clocking. A slave that kept listening would still complete a byte, and one that did not hold the flag would lose it by the time select is released.

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
  parameter int         STALL_W = 16,
  parameter logic [7:0] FILL    = 8'hFF,
  parameter logic       IDLE    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic [STALL_W-1:0] cfg_stall,
  input  logic               sclk,
  input  logic               ss_n,
  input  logic               mosi,
  output logic               miso,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_take,
  output logic               tx_underrun,
  output logic               rx_abort,
  output logic               stall_timeout
);
  logic [2:0] sck_p, sel_p;
  logic [1:0] din_p;
  logic       busy, halted, need_load;
  logic       act_cpol, act_cpha;
  logic [STALL_W-1:0] act_stall, idle_cnt;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sr, tx_sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      sel_p <= '1;
      din_p <= '0;
    end else begin
      sck_p <= {sck_p[1:0], sclk};
      sel_p <= {sel_p[1:0], ss_n};
      din_p <= {din_p[0], mosi};
    end

  wire sck_edge = sck_p[2] ^ sck_p[1];
  wire lead     = sck_edge & (sck_p[1] != act_cpol);
  wire trail    = sck_edge & (sck_p[1] == act_cpol);
  wire samp     = act_cpha ? trail : lead;
  wire drive    = act_cpha ? lead : trail;
  wire fr_start = ~busy & ~sel_p[1];
  wire fr_stop  = busy & sel_p[1];
  wire run      = busy & ~sel_p[1] & ~halted;
  wire fetch    = fr_start | (run & drive & need_load);
  wire [7:0] rx_next = {rx_sr[6:0], din_p[1]};

  assign miso = (busy & ~halted) ? tx_sr[7] : IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; halted <= 1'b0; need_load <= 1'b0;
      act_cpol <= 1'b0; act_cpha <= 1'b0; act_stall <= '0; idle_cnt <= '0;
      bit_cnt <= '0; rx_sr <= '0; tx_sr <= FILL; rx_data <= '0;
      rx_valid <= 1'b0; tx_take <= 1'b0; tx_underrun <= 1'b0;
      rx_abort <= 1'b0; stall_timeout <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      rx_abort <= 1'b0;
      if (!busy) begin
        act_cpol  <= cfg_cpol;
        act_cpha  <= cfg_cpha;
        act_stall <= cfg_stall;
      end
      if (fetch) begin
        tx_sr   <= tx_valid ? tx_data : FILL;
        tx_take <= tx_valid;
      end
      if (fr_start) begin
        busy <= 1'b1; halted <= 1'b0; need_load <= 1'b0;
        bit_cnt <= '0; idle_cnt <= '0;
        stall_timeout <= 1'b0;
        tx_underrun <= ~tx_valid;
      end else if (fr_stop) begin
        busy <= 1'b0;
        if (!halted && bit_cnt != 3'd0) rx_abort <= 1'b1;
      end else if (run) begin
        if (sck_edge) idle_cnt <= '0;
        else if (idle_cnt == act_stall) begin
          halted <= 1'b1;
          stall_timeout <= 1'b1;
        end else idle_cnt <= idle_cnt + 1'b1;
        if (samp) begin
          rx_sr   <= rx_next;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_data   <= rx_next;
            rx_valid  <= 1'b1;
            need_load <= 1'b1;
          end
        end
        if (drive) begin
          if (need_load) begin
            need_load <= 1'b0;
            if (!tx_valid) tx_underrun <= 1'b1;
          end else if (bit_cnt != 3'd0) tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
endmodule

// File: rtl/spi_os_slave_chk.sv
module spi_os_slave_chk #(
  parameter logic IDLE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic ss_n,
  input logic miso,
  input logic rx_valid,
  input logic rx_abort,
  input logic stall_timeout,
  input logic busy,
  input logic halted,
  input logic fr_start,
  input logic act_cpol,
  input logic act_cpha
);
  p_idle_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> (miso == IDLE && !rx_valid));

  p_abort_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> $past(ss_n, 3));

  p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_timeout && !fr_start) |=> stall_timeout);

  p_halt_no_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> !rx_valid);

  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act_cpol) && $stable(act_cpha)));
endmodule

bind spi_os_slave spi_os_slave_chk #(.IDLE(IDLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .miso(miso), .rx_valid(rx_valid),
  .rx_abort(rx_abort), .stall_timeout(stall_timeout), .busy(busy),
  .halted(halted), .fr_start(fr_start), .act_cpol(act_cpol), .act_cpha(act_cpha)
);

// File: tb/tb_spi_os_slave.sv
module tb_spi_os_slave;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [15:0] cfg_stall = 16'd100;
  logic sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic tx_valid = 1'b1;
  logic [7:0] tx_arr [0:7];
  int tx_i = 0, rx_n = 0, ab_n = 0, checks = 0, errors = 0;
  logic [7:0] rx_log [0:15];
  logic m_cpol = 1'b0, m_cpha = 1'b0;
  logic miso, rx_valid, tx_take, tx_underrun, rx_abort, stall_timeout;
  logic [7:0] rx_data;
  wire [7:0] tx_data = tx_arr[tx_i % 8];

  spi_os_slave dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_stall(cfg_stall), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_take(tx_take), .tx_underrun(tx_underrun), .rx_abort(rx_abort),
    .stall_timeout(stall_timeout)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin rx_log[rx_n % 16] = rx_data; rx_n++; end
    if (tx_take) tx_i++;
    if (rx_abort) ab_n++;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] mo, input int n, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      if (!m_cpha) begin
        mosi = mo[i]; wclk(HP); mi[i] = miso;
        sclk = ~m_cpol; wclk(HP); sclk = m_cpol;
      end else begin
        sclk = ~m_cpol; mosi = mo[i]; wclk(HP); mi[i] = miso;
        sclk = m_cpol; wclk(HP);
      end
    end
  endtask

  task automatic begin_frame(input logic pol, input logic pha);
    m_cpol = pol; m_cpha = pha; sclk = pol;
    wclk(4);
    tx_i = 0;
    ss_n = 1'b0; wclk(6);
  endtask

  task automatic end_frame;
    wclk(HP); ss_n = 1'b1; wclk(10);
  endtask

  task automatic t_reset;
    bit ok = 1'b1;
    for (int k = 0; k < 12; k++) begin
      ss_n = k[0]; sclk = k[1]; mosi = k[2]; wclk(1);
      if (miso !== 1'b1 || rx_valid !== 1'b0 || tx_take !== 1'b0 || rx_abort !== 1'b0
          || tx_underrun !== 1'b0 || stall_timeout !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R9 outputs at defaults in reset", miso, 1);
    ss_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
    wclk(2); rst_n = 1'b1; wclk(4);
  endtask

  task automatic t_mode(input logic pol, input logic pha, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] t0, input logic [7:0] t1);
    logic [7:0] m0, m1;
    int base;
    cfg_cpol = pol; cfg_cpha = pha; tx_arr[0] = t0; tx_arr[1] = t1; tx_valid = 1'b1;
    begin_frame(pol, pha);
    base = rx_n;
    xfer(b0, 8, m0); xfer(b1, 8, m1);
    end_frame;
    chk(rx_n == base + 2 && rx_log[base % 16] == b0 && rx_log[(base + 1) % 16] == b1,
        $sformatf("R1 R3 rx bytes mode %0d%0d", pol, pha), rx_log[(base + 1) % 16], b1);
    chk(m0 == t0 && m1 == t1, $sformatf("R2 R3 miso bytes mode %0d%0d", pol, pha), {m0, m1}, {t0, t1});
    chk(tx_underrun == 1'b0, "R5 no underrun with valid data", tx_underrun, 0);
  endtask

  task automatic t_underrun;
    logic [7:0] m0, m1;
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; tx_valid = 1'b0; tx_arr[0] = 8'h3C;
    begin_frame(1'b0, 1'b1);
    xfer(8'h11, 8, m0);
    end_frame;
    chk(m0 == 8'hFF && tx_underrun == 1'b1, "R5 fill byte when data absent at start", m0, 8'hFF);
    chk(tx_i == 0, "R5 no take pulse without valid", tx_i, 0);
    tx_valid = 1'b1; tx_arr[0] = 8'hC3;
    begin_frame(1'b0, 1'b1);
    xfer(8'h22, 8, m0);
    tx_valid = 1'b0;
    xfer(8'h33, 8, m1);
    end_frame;
    chk(m0 == 8'hC3 && m1 == 8'hFF && tx_underrun == 1'b1, "R5 late data gives fill and flag", m1, 8'hFF);
    tx_valid = 1'b1;
  endtask

  task automatic t_abort;
    logic [7:0] m0;
    int base, ab0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; tx_arr[0] = 8'h96; tx_arr[1] = 8'h00;
    base = rx_n; ab0 = ab_n;
    begin_frame(1'b0, 1'b0);
    xfer(8'hE0, 3, m0);
    end_frame;
    chk(ab_n == ab0 + 1, "R4 abort pulse on mid-byte release", ab_n - ab0, 1);
    chk(rx_n == base, "R4 partial byte discarded", rx_n - base, 0);
    begin_frame(1'b0, 1'b0);
    xfer(8'h5A, 8, m0);
    end_frame;
    chk(rx_n == base + 1 && rx_log[base % 16] == 8'h5A && m0 == 8'h96,
        "R4 next frame restarts at bit 7", rx_log[base % 16], 8'h5A);
  endtask

  task automatic t_timeout;
    logic [7:0] m0;
    int base, ab0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_stall = 16'd100; tx_arr[0] = 8'h00; tx_arr[1] = 8'h00;
    base = rx_n; ab0 = ab_n;
    begin_frame(1'b0, 1'b0);
    xfer(8'hAA, 3, m0);
    wclk(250);
    chk(stall_timeout == 1'b1, "R6 timeout flag after stall", stall_timeout, 1);
    chk(miso == 1'b1, "R6 miso idle after timeout", miso, 1);
    xfer(8'h0F, 8, m0);
    chk(rx_n == base, "R6 edges ignored after timeout", rx_n - base, 0);
    end_frame;
    chk(stall_timeout == 1'b1 && ab_n == ab0, "R6 flag held, no abort after timeout", ab_n - ab0, 0);
    tx_arr[0] = 8'h42;
    begin_frame(1'b0, 1'b0);
    chk(stall_timeout == 1'b0, "R6 flag cleared at next frame start", stall_timeout, 0);
    xfer(8'h81, 8, m0);
    end_frame;
    chk(rx_log[base % 16] == 8'h81 && m0 == 8'h42, "R6 normal frame after timeout", rx_log[base % 16], 8'h81);
  endtask

  task automatic t_midchange;
    logic [7:0] m0, m1;
    int base;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; tx_arr[0] = 8'hA5; tx_arr[1] = 8'h7E; tx_arr[2] = 8'h00;
    base = rx_n;
    begin_frame(1'b0, 1'b0);
    xfer(8'h69, 8, m0);
    cfg_cpol = 1'b1; cfg_cpha = 1'b1;
    xfer(8'hD2, 8, m1);
    end_frame;
    chk(rx_log[(base + 1) % 16] == 8'hD2 && rx_n == base + 2, "R7 mid-frame change deferred (rx)",
        rx_log[(base + 1) % 16], 8'hD2);
    chk(m0 == 8'hA5 && m1 == 8'h7E, "R7 mid-frame change deferred (miso)", m1, 8'h7E);
    tx_arr[0] = 8'h1B;
    base = rx_n;
    begin_frame(1'b1, 1'b1);
    xfer(8'hE4, 8, m0);
    end_frame;
    chk(rx_log[base % 16] == 8'hE4 && m0 == 8'h1B, "R7 new mode applies next frame", rx_log[base % 16], 8'hE4);
  endtask

  task automatic t_deselect;
    int base;
    bit ok = 1'b1;
    base = rx_n;
    ss_n = 1'b1; sclk = 1'b0;
    for (int k = 0; k < 16; k++) begin
      mosi = k[0]; sclk = 1'b1; wclk(HP);
      if (miso !== 1'b1) ok = 1'b0;
      sclk = 1'b0; wclk(HP);
    end
    chk(ok, "R8 miso idle while deselected", miso, 1);
    chk(rx_n == base, "R8 no bytes while deselected", rx_n - base, 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) tx_arr[k] = 8'h00;
    t_reset;
    t_mode(1'b0, 1'b0, 8'hA3, 8'h5C, 8'h96, 8'h0F);
    t_mode(1'b0, 1'b1, 8'h81, 8'h7E, 8'hC5, 8'h3A);
    t_mode(1'b1, 1'b0, 8'h12, 8'hED, 8'h80, 8'h01);
    t_mode(1'b1, 1'b1, 8'hF0, 8'h0F, 8'h5A, 8'hB4);
    t_underrun;
    t_abort;
    t_timeout;
    t_midchange;
    t_deselect;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule